// File: doc/BRIEF.md
# Capture/Compare Timer Channel

One channel of a timer that shares a free-running modulo counter with its neighbours. The channel holds a single register the width of the counter. In capture mode, a chosen transition on the channel pin copies the counter value into that register, which allows an event to be time-stamped. Two captures on opposite edges measure a pulse width. In compare mode, the register is a match value. When the counter reaches it, the channel drives its output pin high, drives it low or inverts it. Both modes report through a shared event flag. A second flag latches the counter's overflow strobe.

Software loads the register in two halves, high half first. Compare is held off from the high-half write until the low half arrives, so a half-written value never matches. Writes are not buffered. A new match value applies in the very next cycle, so a value the counter has already passed is missed until the next period. The register has no reset, so a captured or programmed value survives a reset of the channel.

Resolution is one counter value. The channel acts only when equality first appears, so a counter that holds its value for several clocks (a prescaled counter) fires a match once.

Top module: `tmrChannel`

## Requirements
- R1: After reset `pinOut`, `evtFlag` and `ovfFlag` are 0.
- R2: Reset does not change `chValue`. A value loaded before a reset reads back unchanged after it.
- R3: In capture mode (`cmpMode`=0), a pin transition selected by `edgeSel` (01 rising, 10 falling, 11 either) is synchronized through two flops. If `pinIn` changes before clock edge k, `chValue` takes the `cntVal` sampled at edge k+2 and `evtFlag` sets at that same edge. `chValue` is unchanged after edges k and k+1.
- R4: With `edgeSel`=00, or with a transition the selection excludes, `chValue` and `evtFlag` are unaffected.
- R5: In compare mode (`cmpMode`=1), at the clock edge where `cntVal` newly equals `chValue`, `pinOut` takes the action chosen by `cmpAct` (00 none, 01 toggle, 10 drive 0, 11 drive 1) and `evtFlag` sets, even for action 00.
- R6: A match fires once per run of equal counter values. A counter held at the match value for several clocks acts on the pin once.
- R7: A write of the match value takes effect at once. If the counter has passed the new value but not the old one, no match occurs until the counter reaches the new value in the next period.
- R8: `wrSel`=00 writes the upper half and disables compare. `wrSel`=01 writes the lower half and re-enables it. While compare is disabled, equality causes no pin action.
- R9: In capture mode `pinOut` never changes. In compare mode pin edges do not alter `chValue`.
- R10: `ovfFlag` sets at the clock edge where `cntOvf` is sampled high.
- R11: A write with `wrSel`=10 clears `evtFlag` where `wrData[0]` is 0 and clears `ovfFlag` where `wrData[1]` is 0. A data bit of 1 leaves its flag unchanged. A hardware set in the same cycle wins over the clear.
- R12: Half writes assemble `chValue`: upper half = `wrData` from the `wrSel`=00 write, lower half = `wrData` from the `wrSel`=01 write, and each write leaves the other half unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntVal | input | CNT_W | Shared modulo counter value |
| cntOvf | input | 1 | Counter overflow strobe |
| pinIn | input | 1 | Channel pin level (asynchronous) |
| cmpMode | input | 1 | 0 capture, 1 compare |
| edgeSel | input | 2 | Capture edge: 00 off, 01 rising, 10 falling, 11 either |
| cmpAct | input | 2 | Match action: 00 none, 01 toggle, 10 drive 0, 11 drive 1 |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 2 | 00 upper half, 01 lower half, 10 flag clear |
| wrData | input | CNT_W/2 | Write data |
| pinOut | output | 1 | Channel pin drive |
| chValue | output | CNT_W | Channel register contents |
| evtFlag | output | 1 | Capture or compare event flag |
| ovfFlag | output | 1 | Overflow flag |

## Verification
The bench builds the channel with an 8-bit counter, which gives 4-bit halves. This makes every match value reachable. The compare sweep covers all 256 match values, a full period each, and confirms one toggle at the expected counter value. Capture is swept over all four edge selections, both pin polarities and starting counts that include the wrap from 255 to 0, where the expected stamp is the start count plus two modulo 256. The narrow counter also keeps the missed-compare, held-off high write and flag-collision cases a few hundred cycles long.

// File: rtl/tmrChanPkg.sv
package tmrChanPkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edgeSel_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } cmpAct_e;

  typedef enum logic [1:0] {
    WR_UPPER = 2'b00,
    WR_LOWER = 2'b01,
    WR_FLAGS = 2'b10,
    WR_SPARE = 2'b11
  } wrSel_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadUpper;
    logic loadLower;
    logic capture;
    logic pinHigh;
    logic pinLow;
    logic pinFlip;
  } chanStrobe_t;

endpackage

// File: rtl/tmrChanCtrl.sv
module tmrChanCtrl
  import tmrChanPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinIn,
  input  logic        cmpMode,
  input  logic [1:0]  edgeSel,
  input  logic [1:0]  cmpAct,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic [1:0]  flagKeep,
  input  logic        cntOvf,
  input  logic        cmpEq,
  output chanStrobe_t strobe,
  output logic        evtFlag,
  output logic        ovfFlag
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lastLvl;
  logic                   riseSeen;
  logic                   fallSeen;
  logic                   edgeHit;
  logic                   eqPrev;
  logic                   armed;
  logic                   match;
  logic                   wrUpper;
  logic                   wrLower;
  logic                   wrFlags;
  logic                   evtSet;
  edgeSel_e               edgeMode;
  cmpAct_e                actMode;
  wrSel_e                 wrKind;

  assign edgeMode = edgeSel_e'(edgeSel);
  assign actMode  = cmpAct_e'(cmpAct);
  assign wrKind   = wrSel_e'(wrSel);

  // pin synchronizer and previous synchronized level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      lastLvl <= 1'b0;
    end else begin
      syncQ   <= {syncQ[TOP-1:0], pinIn};
      lastLvl <= syncQ[TOP];
    end
  end

  assign riseSeen = syncQ[TOP] & ~lastLvl;
  assign fallSeen = ~syncQ[TOP] & lastLvl;

  always_comb begin
    unique case (edgeMode)
      EDGE_RISE: edgeHit = riseSeen;
      EDGE_FALL: edgeHit = fallSeen;
      EDGE_ANY:  edgeHit = riseSeen | fallSeen;
      default:   edgeHit = 1'b0;
    endcase
  end

  // write decode
  assign wrUpper = wrEn && (wrKind == WR_UPPER);
  assign wrLower = wrEn && (wrKind == WR_LOWER);
  assign wrFlags = wrEn && (wrKind == WR_FLAGS);

  // compare arming and equality edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed  <= 1'b1;
      eqPrev <= 1'b1;
    end else begin
      eqPrev <= cmpEq;
      if (wrLower)      armed <= 1'b1;
      else if (wrUpper) armed <= 1'b0;
    end
  end

  assign match = cmpMode && armed && cmpEq && !eqPrev;

  always_comb begin
    strobe           = '0;
    strobe.loadUpper = wrUpper;
    strobe.loadLower = wrLower;
    strobe.capture   = !cmpMode && edgeHit;
    if (match) begin
      unique case (actMode)
        ACT_TOGGLE: strobe.pinFlip = 1'b1;
        ACT_LOW:    strobe.pinLow  = 1'b1;
        ACT_HIGH:   strobe.pinHigh = 1'b1;
        default:    ;
      endcase
    end
  end

  assign evtSet = match || strobe.capture;

  // flags: hardware set beats software clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtFlag <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      if (evtSet)                      evtFlag <= 1'b1;
      else if (wrFlags && !flagKeep[0]) evtFlag <= 1'b0;
      if (cntOvf)                      ovfFlag <= 1'b1;
      else if (wrFlags && !flagKeep[1]) ovfFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/tmrChanData.sv
module tmrChanData
  import tmrChanPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [HALF_W-1:0] wrData,
  input  chanStrobe_t       strobe,
  output logic [CNT_W-1:0]  chValue,
  output logic              cmpEq,
  output logic              pinOut
);

  localparam int LO_W = CNT_W - HALF_W;

  // channel register: deliberately outside reset
  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      chValue <= cntVal;
    end else begin
      if (strobe.loadUpper) chValue[CNT_W-1:LO_W] <= wrData;
      if (strobe.loadLower) chValue[LO_W-1:0]     <= wrData[LO_W-1:0];
    end
  end

  assign cmpEq = (cntVal == chValue);

  always_ff @(posedge clk) begin
    if (!rstN)               pinOut <= 1'b0;
    else if (strobe.pinHigh) pinOut <= 1'b1;
    else if (strobe.pinLow)  pinOut <= 1'b0;
    else if (strobe.pinFlip) pinOut <= ~pinOut;
  end

endmodule

// File: rtl/tmrChannel.sv
module tmrChannel
  import tmrChanPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int HALF_W     = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              cntOvf,
  input  logic              pinIn,
  input  logic              cmpMode,
  input  logic [1:0]        edgeSel,
  input  logic [1:0]        cmpAct,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [HALF_W-1:0] wrData,
  output logic              pinOut,
  output logic [CNT_W-1:0]  chValue,
  output logic              evtFlag,
  output logic              ovfFlag
);

  chanStrobe_t strobe;
  logic        cmpEq;

  tmrChanCtrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .cmpMode  (cmpMode),
    .edgeSel  (edgeSel),
    .cmpAct   (cmpAct),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .flagKeep (wrData[1:0]),
    .cntOvf   (cntOvf),
    .cmpEq    (cmpEq),
    .strobe   (strobe),
    .evtFlag  (evtFlag),
    .ovfFlag  (ovfFlag)
  );

  tmrChanData #(
    .CNT_W  (CNT_W),
    .HALF_W (HALF_W)
  ) data_i (
    .clk     (clk),
    .rstN    (rstN),
    .cntVal  (cntVal),
    .wrData  (wrData),
    .strobe  (strobe),
    .chValue (chValue),
    .cmpEq   (cmpEq),
    .pinOut  (pinOut)
  );

endmodule

// File: rtl/tmrChanChk.sv
module tmrChanChk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntOvf,
  input logic             cmpMode,
  input logic             wrEn,
  input logic [1:0]       wrSel,
  input logic             ovfKeep,
  input logic             pinOut,
  input logic [CNT_W-1:0] chValue,
  input logic             evtFlag,
  input logic             ovfFlag
);

  p_pin_quiet_capture_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cmpMode |=> $stable(pinOut));

  p_value_kept_compare_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmpMode && !wrEn) |=> $stable(chValue));

  p_upper_write_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'b00) ##1 !(wrEn && wrSel == 2'b01) |=> $stable(pinOut));

  p_pin_change_flags_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pinOut) |-> evtFlag);

  p_ovf_sets_r10: assert property (@(posedge clk) disable iff (!rstN)
    cntOvf |=> ovfFlag);

  p_set_beats_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cntOvf && wrEn && wrSel == 2'b10 && !ovfKeep) |=> ovfFlag);

endmodule

bind tmrChannel tmrChanChk #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .cntOvf  (cntOvf),
  .cmpMode (cmpMode),
  .wrEn    (wrEn),
  .wrSel   (wrSel),
  .ovfKeep (wrData[1]),
  .pinOut  (pinOut),
  .chValue (chValue),
  .evtFlag (evtFlag),
  .ovfFlag (ovfFlag)
);

// File: tb/tmrChannel_tb_top.sv
module tmrChannel_tb_top;

  localparam int CW = 8;
  localparam int HW = CW / 2;

  logic          clk = 1'b0;
  logic          rstN;
  logic [CW-1:0] cnt;
  logic [CW-1:0] seen;
  logic          run;
  logic          cntOvf;
  logic          pinIn;
  logic          cmpMode;
  logic [1:0]    edgeSel;
  logic [1:0]    cmpAct;
  logic          wrEn;
  logic [1:0]    wrSel;
  logic [HW-1:0] wrData;
  logic          pinOut;
  logic [CW-1:0] chValue;
  logic          evtFlag;
  logic          ovfFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  assign cntOvf = (cnt == 8'hFF);

  tmrChannel #(.CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .cntVal(cnt), .cntOvf(cntOvf), .pinIn(pinIn),
    .cmpMode(cmpMode), .edgeSel(edgeSel), .cmpAct(cmpAct), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .pinOut(pinOut), .chValue(chValue),
    .evtFlag(evtFlag), .ovfFlag(ovfFlag)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock; seen = counter value the design sampled at this edge
  task automatic step();
    @(posedge clk);
    seen = cnt;
    #2;
    if (run) cnt = cnt + 1'b1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [HW-1:0] d);
    wrEn = 1'b1; wrSel = s; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic setVal(input logic [CW-1:0] v);
    wr(2'b00, v[CW-1:HW]);
    wr(2'b01, v[HW-1:0]);
  endtask

  task automatic hitVal(input logic [CW-1:0] v);
    run = 1'b0;
    cnt = v - 1'b1; step();
    cnt = v;        step();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic p;
    int changes, at;
    logic [CW-1:0] old, start;
    rstN = 0; cnt = 0; seen = 0; run = 0; pinIn = 0; cmpMode = 0;
    edgeSel = 0; cmpAct = 0; wrEn = 0; wrSel = 0; wrData = 0;
    repeat (3) step();
    chk("R1 pinOut", pinOut, 0);
    chk("R1 evtFlag", evtFlag, 0);
    chk("R1 ovfFlag", ovfFlag, 0);
    rstN = 1;
    step();

    // R12 half writes
    setVal(8'hA5);
    chk("R12 full value", chValue, 8'hA5);
    wr(2'b00, 4'h7);
    chk("R12 upper only", chValue, 8'h75);
    wr(2'b01, 4'h2);
    chk("R12 lower only", chValue, 8'h72);

    // R2 value survives reset
    rstN = 0; repeat (2) step(); rstN = 1; step();
    chk("R2 kept through reset", chValue, 8'h72);
    chk("R1 flags after reset", {evtFlag, ovfFlag}, 0);

    // R3/R4 capture sweep
    run = 1;
    for (int sel = 0; sel < 4; sel++) begin
      for (int si = 0; si < 8; si++) begin
        for (int r = 0; r < 2; r++) begin
          bit hit;
          edgeSel = 2'(sel);
          pinIn = r[0];
          repeat (4) step();
          wr(2'b10, 4'h0);
          old = chValue;
          start = 8'(si * 37 + 254);
          cnt = start;
          pinIn = ~pinIn;
          step(); step();
          chk("R3 not yet captured", chValue, old);
          step();
          hit = (sel == 3) || (sel == 1 && r == 0) || (sel == 2 && r == 1);
          if (hit) begin
            chk("R3 capture value", chValue, 8'(start + 2));
            chk("R3 capture flag", evtFlag, 1);
          end else begin
            chk("R4 no capture value", chValue, old);
            chk("R4 no capture flag", evtFlag, 0);
          end
        end
      end
    end
    pinIn = 0; edgeSel = 0; repeat (4) step();

    // R5 toggle sweep over every match value
    cmpMode = 1; cmpAct = 2'b01;
    for (int v = 0; v < 256; v++) begin
      run = 0;
      cnt = 8'(v + 100);
      setVal(8'(v));
      wr(2'b10, 4'h0);
      p = pinOut; changes = 0; at = -1;
      run = 1;
      repeat (256) begin
        step();
        if (pinOut != p) begin changes++; at = seen; p = pinOut; end
      end
      chk("R5 toggles per period", changes, 1);
      chk("R5 match point", at, v);
      chk("R5 event flag", evtFlag, 1);
    end

    // R5 actions
    run = 0; cnt = 0; setVal(8'd20);
    cmpAct = 2'b10; hitVal(8'd20); chk("R5 drive low", pinOut, 0);
    cmpAct = 2'b11; hitVal(8'd20); chk("R5 drive high", pinOut, 1);
    hitVal(8'd20); chk("R5 drive high again", pinOut, 1);
    wr(2'b10, 4'h0);
    cmpAct = 2'b00; hitVal(8'd20);
    chk("R5 no action pin", pinOut, 1);
    chk("R5 no action flag", evtFlag, 1);
    cmpAct = 2'b10; hitVal(8'd20); chk("R5 drive low again", pinOut, 0);

    // R6 held counter acts once
    cmpAct = 2'b01; p = pinOut; changes = 0;
    cnt = 8'd19; step();
    cnt = 8'd20;
    repeat (6) begin step(); if (pinOut != p) begin changes++; p = pinOut; end end
    chk("R6 single action on held count", changes, 1);

    // R7 missed compare after unbuffered write
    run = 0; cnt = 0; setVal(8'd200);
    cnt = 8'd100; run = 1;
    setVal(8'd50);
    chk("R7 new value", chValue, 50);
    p = pinOut; changes = 0;
    while (seen != 8'd255) begin step(); if (pinOut != p) begin changes++; p = pinOut; end end
    chk("R7 no match this period", changes, 0);
    at = -1;
    repeat (70) begin step(); if (pinOut != p) begin changes++; at = seen; p = pinOut; end end
    chk("R7 next period matches", changes, 1);
    chk("R7 next period point", at, 50);

    // R8 upper write holds compare off
    run = 0; cnt = 0; setVal(8'h30);
    cnt = 8'h2E; run = 1; p = pinOut; changes = 0;
    wr(2'b00, 4'h3);
    while (seen != 8'h36) begin step(); if (pinOut != p) begin changes++; p = pinOut; end end
    wr(2'b01, 4'h0);
    chk("R8 held off", changes, 0);
    at = -1;
    repeat (256) begin step(); if (pinOut != p) begin changes++; at = seen; p = pinOut; end end
    chk("R8 re-armed", changes, 1);
    chk("R8 re-armed point", at, 8'h30);

    // R9 capture mode leaves pin; compare mode ignores pin edges
    cmpMode = 0; edgeSel = 0; p = pinOut; changes = 0;
    repeat (256) begin step(); if (pinOut != p) begin changes++; p = pinOut; end end
    chk("R9 pin quiet in capture mode", changes, 0);
    cmpMode = 1; cmpAct = 0; edgeSel = 2'b11; old = chValue;
    pinIn = 1; repeat (5) step();
    pinIn = 0; repeat (5) step();
    chk("R9 no capture in compare mode", chValue, old);
    edgeSel = 0;

    // R10 overflow flag
    run = 0; cnt = 5; wr(2'b10, 4'h0);
    chk("R10 clear before", ovfFlag, 0);
    cnt = 8'd254; step(); chk("R10 not yet", ovfFlag, 0);
    cnt = 8'd255; step(); chk("R10 set on strobe", ovfFlag, 1);

    // R11 flag clear rules
    cnt = 5;
    hitVal(8'h30);
    chk("R11 event set", evtFlag, 1);
    cnt = 5;
    wr(2'b10, 4'b0001);
    chk("R11 ovf cleared", ovfFlag, 0);
    chk("R11 evt kept", evtFlag, 1);
    wr(2'b10, 4'b0010);
    chk("R11 evt cleared", evtFlag, 0);
    chk("R11 ovf stays clear", ovfFlag, 0);
    cnt = 8'd255;
    wr(2'b10, 4'b0000);
    chk("R11 overflow set wins", ovfFlag, 1);
    cnt = 8'h2F; step();
    cnt = 8'h30;
    wr(2'b10, 4'b0000);
    chk("R11 match set wins", evtFlag, 1);

    done = 1;
    summary();
    $finish;
  end

endmodule